// File: doc/BRIEF.md
# Chained Scatter-Gather List Builder

This block turns a byte buffer that spans several fixed-size pages into a scatter-gather descriptor list in memory. A build starts with a pulse on `start`. At that pulse the block captures the list base address, the byte offset of the buffer in its first page, the total byte length and two optional bounce-page addresses. It then asks for one bus address per page through `pg_idx`/`pg_addr`. Pages whose addresses run on from the previous piece are folded into one descriptor. The finished descriptors go out one 16-byte entry at a time through a valid/ready memory write port.

Descriptors are grouped in blocks of eight entries (128 bytes). Every block except the last begins with a link entry that points at the next block, followed by seven data entries. The last block has no link entry. Its data entries start at slot 0 and an end entry follows them. A single `done` pulse closes a successful build and reports the number of data entries. A build that would not fit the configured list capacity, or that has a zero length, ends with `done_err` and writes nothing.

Top module: `sgl_chain_builder`

## Requirements
- R1: Each entry is 16 bytes, with byte k of the entry on `wr_data[8k+7:8k]`. Bytes 0-7 hold the 64-bit address and bytes 8-11 hold the 32-bit length. Bytes 12-15 hold the 32-bit flag word. All three fields are big-endian (most significant byte at the lowest byte number). Flag codes are data = 0, link = 1 and end = 2.
- R2: Every block other than the last one is written with a link entry in slot 0. The link entry has address `base + 128*(b+1)` for block b, length 128 and the link flag. Slots 1-7 of that block hold seven data entries. Entry s of block b is written at `base + 128*b + 16*s`.
- R3: The page count is ceil((offset + length) / PAGE_BYTES). Page p covers min(bytes left, PAGE_BYTES - o) bytes, where o is the first-page offset for p = 0 and 0 for later pages. Its address is the address returned on `pg_addr` for `pg_idx` = p, plus o.
- R4: When head bounce is enabled, page 0 uses the head bounce address plus the first-page offset. When tail bounce is enabled, the last page uses the tail bounce address with no offset added. The head rule takes priority when the buffer has a single page.
- R5: A page whose address equals the end address (address plus length) of the data entry before it extends that entry's length and creates no new entry. The first page of a build always opens a new entry.
- R6: In the last block, the n data entries (1 <= n <= 7) sit in slots 0 to n-1. Slot n holds an end entry with address 0, length 0 and the end flag. Nothing is written after the end entry, and no write falls outside the list region.
- R7: When the data entry count is a multiple of 7 (including the case where the last page merged into the seventh entry of a block), that block is the last block. It holds the seven data entries in slots 0-6 and the end entry in slot 7. No link entry or further block is written.
- R8: When the length is zero, or when 8*ceil((pages + floor(pages/7) + 1)/8) exceeds CAP_ENTRIES, the build ends with a one-cycle `done_err`. It issues no write and no `done`.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values into the next cycle.
- R10: After reset the block is idle with `busy`, `wr_valid`, `done` and `done_err` low. A successful build ends with a one-cycle `done`, taken in the cycle after the end entry is accepted. In that cycle `done_count` equals the number of data entries and `busy` is low.
- R11: A `start` pulse while `busy` is high is ignored. The running build completes with the configuration captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a build; configuration captured on this cycle |
| list_base | input | 64 | Byte address of the descriptor list region |
| first_off | input | log2(PAGE_BYTES) | Byte offset of the buffer within its first page |
| total_len | input | 32 | Buffer length in bytes |
| head_bounce_en | input | 1 | Replace the first page by the head bounce page |
| head_bounce_addr | input | 64 | Head bounce page address |
| tail_bounce_en | input | 1 | Replace the last page by the tail bounce page |
| tail_bounce_addr | input | 64 | Tail bounce page address |
| pg_idx | output | PG_W | Index of the page whose address is requested |
| pg_addr | input | 64 | Bus address of page `pg_idx`, combinational |
| wr_valid | output | 1 | Entry write request |
| wr_ready | input | 1 | Entry write accepted |
| wr_addr | output | 64 | Byte address of the entry |
| wr_data | output | 128 | Entry bytes, byte k on bits 8k+7:8k |
| busy | output | 1 | A build is in progress |
| done | output | 1 | One-cycle pulse: build finished |
| done_err | output | 1 | One-cycle pulse: build refused |
| done_count | output | PG_W+1 | Data entries produced, valid with `done` |

## Verification
The properties assume three things about the inputs: the list base is 16-byte aligned, `pg_addr` settles combinationally for the `pg_idx` on offer, and `wr_ready` may follow any pattern. The stimulus respects all three. It uses 128-aligned bases and a combinational page table in the bench, and it drives `wr_ready` from a pseudo-random stream that often stalls. The sweep covers offsets, lengths, bounce combinations and page-address patterns: scattered, fully contiguous, pairwise contiguous and descending. Every build fits the list region, apart from the directed cases that probe the capacity limit on both sides.

// File: rtl/sgl_build_pkg.sv
package sgl_build_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_CHECK = 3'd1,
        S_WALK  = 3'd2,
        S_FLUSH = 3'd3,
        S_FINAL = 3'd4
    } sgl_state_e;

    localparam logic [31:0] FLG_DATA = 32'd0;
    localparam logic [31:0] FLG_LINK = 32'd1;
    localparam logic [31:0] FLG_STOP = 32'd2;

    localparam int unsigned BLOCK_SLOTS = 8;
    localparam int unsigned BLOCK_BYTES = 128;
    localparam int unsigned ENTRY_SHIFT = 4;
    localparam int unsigned BLOCK_SHIFT = 7;
endpackage

// File: rtl/sgl_entry_pack.sv
module sgl_entry_pack (
    input  logic [63:0]  addr,
    input  logic [31:0]  len,
    input  logic [31:0]  flags,
    output logic [127:0] word
);
    // byte k of the entry lands on word[8k+7:8k]; fields are big-endian
    for (genvar i = 0; i < 8; i++) begin : g_addr
        assign word[8*i +: 8] = addr[63-8*i -: 8];
    end
    for (genvar i = 0; i < 4; i++) begin : g_word
        assign word[64+8*i +: 8] = len[31-8*i -: 8];
        assign word[96+8*i +: 8] = flags[31-8*i -: 8];
    end
endmodule

// File: rtl/sgl_page_walk.sv
module sgl_page_walk #(
    parameter int unsigned PAGE_BYTES = 4096,
    parameter int unsigned PG_W       = 20
) (
    input  logic [PG_W:0]                   page,
    input  logic [PG_W:0]                   npg,
    input  logic [$clog2(PAGE_BYTES)-1:0]   first_off,
    input  logic [31:0]                     rem,
    input  logic                            hb_en,
    input  logic [63:0]                     hb_addr,
    input  logic                            tb_en,
    input  logic [63:0]                     tb_addr,
    input  logic [63:0]                     pg_addr,
    output logic [63:0]                     seg_addr,
    output logic [31:0]                     seg_len
);
    localparam int unsigned OFF_W = $clog2(PAGE_BYTES);

    logic        is_head;
    logic        is_tail;
    logic [31:0] off_eff;
    logic [31:0] span;

    always_comb begin
        is_head = (page == '0);
        is_tail = (page == npg - 1'b1);
        off_eff = is_head ? {{(32-OFF_W){1'b0}}, first_off} : 32'd0;
        span    = 32'(PAGE_BYTES) - off_eff;
        seg_len = (rem < span) ? rem : span;
        if (is_head && hb_en) begin
            seg_addr = hb_addr + {32'd0, off_eff};
        end else if (is_tail && tb_en) begin
            seg_addr = tb_addr;
        end else begin
            seg_addr = pg_addr + {32'd0, off_eff};
        end
    end
endmodule

// File: rtl/sgl_size_check.sv
module sgl_size_check #(
    parameter int unsigned PAGE_BYTES  = 4096,
    parameter int unsigned CAP_ENTRIES = 64,
    parameter int unsigned PG_W        = 20
) (
    input  logic [$clog2(PAGE_BYTES)-1:0] first_off,
    input  logic [31:0]                   total_len,
    output logic [PG_W:0]                 npg,
    output logic                          too_big
);
    localparam int unsigned SH = $clog2(PAGE_BYTES);

    logic [39:0] span_bytes;
    logic [39:0] pages_full;
    logic [39:0] slots;
    logic [39:0] need;

    always_comb begin
        span_bytes = 40'(first_off) + 40'(total_len) + 40'(PAGE_BYTES - 1);
        pages_full = span_bytes >> SH;
        slots      = pages_full + pages_full / 40'd7 + 40'd1;
        need       = ((slots + 40'd7) >> 3) << 3;
        too_big    = (total_len == 32'd0) || (need > 40'(CAP_ENTRIES));
        npg        = pages_full[PG_W:0];
    end
endmodule

// File: rtl/sgl_chain_builder.sv
module sgl_chain_builder
    import sgl_build_pkg::*;
#(
    parameter int unsigned PAGE_BYTES  = 4096,
    parameter int unsigned CAP_ENTRIES = 64,
    parameter int unsigned PG_W        = 20
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [63:0]                   list_base,
    input  logic [$clog2(PAGE_BYTES)-1:0] first_off,
    input  logic [31:0]                   total_len,
    input  logic                          head_bounce_en,
    input  logic [63:0]                   head_bounce_addr,
    input  logic                          tail_bounce_en,
    input  logic [63:0]                   tail_bounce_addr,
    output logic [PG_W-1:0]               pg_idx,
    input  logic [63:0]                   pg_addr,
    output logic                          wr_valid,
    input  logic                          wr_ready,
    output logic [63:0]                   wr_addr,
    output logic [127:0]                  wr_data,
    output logic                          busy,
    output logic                          done,
    output logic                          done_err,
    output logic [PG_W:0]                 done_count
);
    localparam int unsigned OFF_W = $clog2(PAGE_BYTES);
    localparam int unsigned BLK_W = $clog2(CAP_ENTRIES / BLOCK_SLOTS) + 1;
    localparam int unsigned DSLOT = BLOCK_SLOTS - 1;

    typedef struct packed {
        sgl_state_e                st;
        logic [63:0]               base;
        logic [OFF_W-1:0]          off;
        logic [31:0]               len;
        logic                      hb_en;
        logic [63:0]               hb_addr;
        logic                      tb_en;
        logic [63:0]               tb_addr;
        logic [PG_W:0]             npg;
        logic [PG_W:0]             page;
        logic [31:0]               rem;
        logic                      open_v;
        logic [63:0]               open_a;
        logic [31:0]               open_l;
        logic [2:0]                cnt;
        logic [DSLOT-1:0][63:0]    buf_a;
        logic [DSLOT-1:0][31:0]    buf_l;
        logic [BLK_W-1:0]          blk;
        logic [2:0]                slot;
        logic [PG_W:0]             ndata;
        logic                      done;
        logic                      err;
    } ctx_t;

    ctx_t q, d;

    logic [PG_W:0] chk_npg;
    logic          chk_too_big;
    logic [63:0]   seg_addr;
    logic [31:0]   seg_len;
    logic [63:0]   ent_addr;
    logic [31:0]   ent_len;
    logic [31:0]   ent_flags;
    logic [63:0]   blk_off;
    logic [2:0]    prev_slot;

    sgl_size_check #(
        .PAGE_BYTES (PAGE_BYTES),
        .CAP_ENTRIES(CAP_ENTRIES),
        .PG_W       (PG_W)
    ) u_size (
        .first_off(q.off),
        .total_len(q.len),
        .npg      (chk_npg),
        .too_big  (chk_too_big)
    );

    sgl_page_walk #(
        .PAGE_BYTES(PAGE_BYTES),
        .PG_W      (PG_W)
    ) u_walk (
        .page     (q.page),
        .npg      (q.npg),
        .first_off(q.off),
        .rem      (q.rem),
        .hb_en    (q.hb_en),
        .hb_addr  (q.hb_addr),
        .tb_en    (q.tb_en),
        .tb_addr  (q.tb_addr),
        .pg_addr  (pg_addr),
        .seg_addr (seg_addr),
        .seg_len  (seg_len)
    );

    sgl_entry_pack u_pack (
        .addr (ent_addr),
        .len  (ent_len),
        .flags(ent_flags),
        .word (wr_data)
    );

    // next-state computation
    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.st      = S_CHECK;
                    d.base    = list_base;
                    d.off     = first_off;
                    d.len     = total_len;
                    d.hb_en   = head_bounce_en;
                    d.hb_addr = head_bounce_addr;
                    d.tb_en   = tail_bounce_en;
                    d.tb_addr = tail_bounce_addr;
                end
            end
            S_CHECK: begin
                if (chk_too_big) begin
                    d.err = 1'b1;
                    d.st  = S_IDLE;
                end else begin
                    d.npg    = chk_npg;
                    d.page   = '0;
                    d.rem    = q.len;
                    d.open_v = 1'b0;
                    d.cnt    = '0;
                    d.blk    = '0;
                    d.ndata  = '0;
                    d.st     = S_WALK;
                end
            end
            S_WALK: begin
                if (q.cnt == 3'(DSLOT)) begin
                    // seven closed entries plus an open one: block is not last
                    d.st   = S_FLUSH;
                    d.slot = '0;
                end else if (q.page == q.npg) begin
                    d.st   = S_FINAL;
                    d.slot = '0;
                end else begin
                    d.page = q.page + 1'b1;
                    d.rem  = q.rem - seg_len;
                    if (q.open_v && (seg_addr == q.open_a + {32'd0, q.open_l})) begin
                        d.open_l = q.open_l + seg_len;
                    end else begin
                        if (q.open_v) begin
                            d.buf_a[q.cnt] = q.open_a;
                            d.buf_l[q.cnt] = q.open_l;
                            d.cnt          = q.cnt + 3'd1;
                        end
                        d.open_v = 1'b1;
                        d.open_a = seg_addr;
                        d.open_l = seg_len;
                        d.ndata  = q.ndata + 1'b1;
                    end
                end
            end
            S_FLUSH: begin
                if (wr_ready) begin
                    if (q.slot == 3'(DSLOT)) begin
                        d.blk = q.blk + 1'b1;
                        d.cnt = '0;
                        d.st  = S_WALK;
                    end else begin
                        d.slot = q.slot + 3'd1;
                    end
                end
            end
            S_FINAL: begin
                if (wr_ready) begin
                    if (q.slot == q.cnt + 3'd1) begin
                        d.done = 1'b1;
                        d.st   = S_IDLE;
                    end else begin
                        d.slot = q.slot + 3'd1;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    // entry currently offered on the write port
    always_comb begin
        blk_off   = {{(64-BLK_W){1'b0}}, q.blk} << BLOCK_SHIFT;
        prev_slot = q.slot - 3'd1;
        wr_addr   = q.base + blk_off + ({61'd0, q.slot} << ENTRY_SHIFT);
        ent_addr  = 64'd0;
        ent_len   = 32'd0;
        ent_flags = FLG_STOP;
        if (q.st == S_FLUSH) begin
            if (q.slot == 3'd0) begin
                ent_addr  = q.base + blk_off + 64'(BLOCK_BYTES);
                ent_len   = 32'(BLOCK_BYTES);
                ent_flags = FLG_LINK;
            end else begin
                ent_addr  = q.buf_a[prev_slot];
                ent_len   = q.buf_l[prev_slot];
                ent_flags = FLG_DATA;
            end
        end else if (q.st == S_FINAL) begin
            if (q.slot < q.cnt) begin
                ent_addr  = q.buf_a[q.slot];
                ent_len   = q.buf_l[q.slot];
                ent_flags = FLG_DATA;
            end else if (q.slot == q.cnt) begin
                ent_addr  = q.open_a;
                ent_len   = q.open_l;
                ent_flags = FLG_DATA;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pg_idx     = q.page[PG_W-1:0];
    assign wr_valid   = (q.st == S_FLUSH) || (q.st == S_FINAL);
    assign busy       = (q.st != S_IDLE);
    assign done       = q.done;
    assign done_err   = q.err;
    assign done_count = q.ndata;
endmodule

// File: rtl/sgl_chain_builder_chk.sv
module sgl_chain_builder_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic         wr_valid,
    input logic         wr_ready,
    input logic [63:0]  wr_addr,
    input logic [127:0] wr_data,
    input logic         done,
    input logic         done_err
);
    logic is_link;
    logic is_stop;
    assign is_link = (wr_data[127:96] == 32'h0100_0000);
    assign is_stop = (wr_data[127:96] == 32'h0200_0000);

    // R9: a stalled write keeps its request, address and data
    a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    // R1: flag word carries one of the three codes, big-endian
    a_r1_flag_code: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_data[119:96] == 24'd0) && (wr_data[127:120] <= 8'd2));

    // R1: entries sit on 16-byte boundaries of an aligned region
    a_r1_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[3:0] == 4'd0));

    // R2: link entries always span one 128-byte block
    a_r2_link_len: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && is_link |-> (wr_data[95:64] == 32'h8000_0000));

    // R6: the end entry is zero-filled and closes the build
    a_r6_stop_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && is_stop |-> (wr_data[95:0] == 96'd0));
    a_r6_stop_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready && is_stop |=> done);

    // R10: one result per build, and the block is idle when it is reported
    a_r10_single_result: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, done_err}));
    a_r10_idle_on_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done || done_err) |-> !busy && !wr_valid);
    a_r10_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> busy);

    // R8: a refused build issued no write just before its report
    a_r8_refuse_silent: assert property (@(posedge clk) disable iff (!rst_n)
        done_err |-> !$past(wr_valid));
endmodule

bind sgl_chain_builder sgl_chain_builder_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .wr_valid(wr_valid),
    .wr_ready(wr_ready),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .done    (done),
    .done_err(done_err)
);

// File: tb/sgl_chain_builder_bench.sv
module sgl_chain_builder_bench;
    localparam int PB  = 64;
    localparam int CAP = 32;
    localparam int PGW = 8;
    localparam logic [127:0] SENT = {4{32'hA5C3_5A3C}};
    localparam logic [63:0]  HB = 64'h7000_0000;
    localparam logic [63:0]  TB = 64'h7100_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [63:0]  list_base = '0;
    logic [5:0]   first_off = '0;
    logic [31:0]  total_len = '0;
    logic         hb_en = 1'b0, tb_en = 1'b0;
    logic [PGW-1:0] pg_idx;
    logic [63:0]  pg_addr;
    logic         wr_valid, wr_ready = 1'b1;
    logic [63:0]  wr_addr;
    logic [127:0] wr_data;
    logic         busy, done, done_err;
    logic [PGW:0] done_count;

    always #4 clk = ~clk;

    sgl_chain_builder #(.PAGE_BYTES(PB), .CAP_ENTRIES(CAP), .PG_W(PGW)) u_sgl_chain_builder (
        .clk(clk), .rst_n(rst_n), .start(start), .list_base(list_base),
        .first_off(first_off), .total_len(total_len),
        .head_bounce_en(hb_en), .head_bounce_addr(HB),
        .tail_bounce_en(tb_en), .tail_bounce_addr(TB),
        .pg_idx(pg_idx), .pg_addr(pg_addr),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .done_err(done_err), .done_count(done_count)
    );

    int mode = 0;
    int tests = 0, fails = 0;
    int stall_on = 1;

    function automatic logic [63:0] page_fn(int m, int p);
        case (m)
            0: page_fn = 64'h0010_0000 + 64'(p) * 64'h200;
            1: page_fn = 64'h0020_0000 + 64'(p) * 64'(PB);
            2: page_fn = 64'h0030_0000 + 64'(p / 2) * 64'h400 + 64'(p % 2) * 64'(PB);
            3: page_fn = 64'h0040_0000 + 64'(63 - p) * 64'(PB);
            default: page_fn = 64'h0102_0304_0506_0708 + 64'(p) * 64'h1000;
        endcase
    endfunction
    assign pg_addr = page_fn(mode, int'(pg_idx));

    function automatic logic [127:0] pack(logic [63:0] a, logic [31:0] l, logic [31:0] f);
        logic [127:0] w;
        for (int i = 0; i < 8; i++) w[8*i +: 8] = a[63-8*i -: 8];
        for (int i = 0; i < 4; i++) begin
            w[64+8*i +: 8] = l[31-8*i -: 8];
            w[96+8*i +: 8] = f[31-8*i -: 8];
        end
        return w;
    endfunction

    // capture model
    logic [127:0] mem [CAP];
    logic [127:0] first_word;
    int nwr = 0, oob = 0, hold_bad = 0;
    logic hold_pend = 1'b0;
    logic [63:0] hold_a;
    logic [127:0] hold_d;
    logic got_done = 1'b0, got_err = 1'b0;
    int got_cnt = 0;
    int cyc = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (hold_pend && (!wr_valid || wr_addr != hold_a || wr_data != hold_d)) hold_bad++;
            hold_pend = 1'b0;
            if (wr_valid && !wr_ready) begin
                hold_pend = 1'b1; hold_a = wr_addr; hold_d = wr_data;
            end
            if (wr_valid && wr_ready) begin
                if (nwr == 0) first_word = wr_data;
                nwr++;
                if (wr_addr < list_base || wr_addr[3:0] != 4'd0 ||
                    ((wr_addr - list_base) >> 4) >= 64'(CAP)) oob++;
                else mem[int'((wr_addr - list_base) >> 4)] = wr_data;
            end
            if (done) begin got_done = 1'b1; got_cnt = int'(done_count); end
            if (done_err) got_err = 1'b1;
        end
    end

    always @(negedge clk) begin
        lcg <= lcg * 32'd1103515245 + 32'd12345;
        wr_ready <= stall_on == 0 ? 1'b1 : (lcg[16] | lcg[19]);
    end

    task automatic summary_and_end();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) if (cyc == 195000) begin
        tests++; fails++;
        $display("FAIL R10 watchdog expired actual=%0d expected=<195000", cyc);
        summary_and_end();
    end

    task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected model
    logic [127:0] expw [CAP];
    logic [63:0] ea [64];
    logic [31:0] el [64];
    int exp_d, exp_err;

    task automatic model(input int off, input int len, input int m, input bit hb, input bit tb, input logic [63:0] base);
        int n, rem, o, sz, f, k;
        logic [63:0] a;
        n = (off + len + PB - 1) / PB;
        exp_err = (len == 0) || (8 * ((n + n / 7 + 1 + 7) / 8) > CAP);
        for (int e = 0; e < CAP; e++) expw[e] = SENT;
        exp_d = 0;
        if (exp_err) return;
        rem = len;
        for (int p = 0; p < n; p++) begin
            o = (p == 0) ? off : 0;
            sz = (rem < PB - o) ? rem : PB - o;
            if (p == 0 && hb) a = HB + 64'(o);
            else if (p == n - 1 && tb) a = TB;
            else a = page_fn(m, p) + 64'(o);
            rem -= sz;
            if (exp_d > 0 && a == ea[exp_d-1] + 64'(el[exp_d-1])) el[exp_d-1] += 32'(sz);
            else begin ea[exp_d] = a; el[exp_d] = 32'(sz); exp_d++; end
        end
        f = (exp_d - 1) / 7;
        for (int b = 0; b < f; b++) begin
            expw[b*8] = pack(base + 64'((b + 1) * 128), 32'd128, 32'd1);
            for (int i = 0; i < 7; i++) expw[b*8+1+i] = pack(ea[b*7+i], el[b*7+i], 32'd0);
        end
        k = exp_d - 7 * f;
        for (int i = 0; i < k; i++) expw[f*8+i] = pack(ea[7*f+i], el[7*f+i], 32'd0);
        expw[f*8+k] = pack(64'd0, 32'd0, 32'd2);
    endtask

    task automatic run(input int off, input int len, input int m, input bit hb, input bit tb,
                       input logic [63:0] base, input string lbl, input bit poke);
        int w;
        int bad;
        model(off, len, m, hb, tb, base);
        for (int e = 0; e < CAP; e++) mem[e] = SENT;
        @(negedge clk);
        nwr = 0; oob = 0; got_done = 1'b0; got_err = 1'b0;
        mode = m; list_base = base; first_off = 6'(off); total_len = 32'(len);
        hb_en = hb; tb_en = tb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R11: a second start with another configuration while busy
            @(negedge clk);
            total_len = 32'(len + 300); first_off = 6'd0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (!got_done && !got_err && w < 3000) begin @(negedge clk); w++; end
        if (exp_err) begin
            chk(got_err && !got_done, "R8 refusal reported", 128'({got_done, got_err}), 128'b01);
            chk(nwr == 0, "R8 no writes on refusal", 128'(nwr), 128'd0);
        end else begin
            chk(got_done && !got_err, {lbl, " build completes (R10)"}, 128'({got_done, got_err}), 128'b10);
            chk(got_cnt == exp_d, "R10 data entry count", 128'(got_cnt), 128'(exp_d));
            chk(oob == 0, "R6 writes inside list region", 128'(oob), 128'd0);
            bad = -1;
            for (int e = 0; e < CAP; e++) if (bad < 0 && mem[e] != expw[e]) bad = e;
            if (bad < 0) chk(1'b1, lbl, 0, 0);
            else if (expw[bad][127:96] == 32'h0100_0000) chk(1'b0, "R2 link entry", mem[bad], expw[bad]);
            else if (expw[bad][127:96] == 32'h0200_0000) chk(1'b0, "R6 end entry", mem[bad], expw[bad]);
            else chk(1'b0, {lbl, " list contents"}, mem[bad], expw[bad]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !wr_valid && !done && !done_err, "R10 reset idle",
            128'({busy, wr_valid, done, done_err}), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: byte layout of a single data entry, no stalls
        stall_on = 0;
        run(0, 5, 4, 1'b0, 1'b0, 64'h8000_0000, "R1", 1'b0);
        chk(first_word == {32'h0, 32'h0500_0000, 64'h0807_0605_0403_0201}, "R1 entry bytes",
            first_word, {32'h0, 32'h0500_0000, 64'h0807_0605_0403_0201});
        stall_on = 1;

        // R7: seven entries exactly, with and without a merge on the last page
        run(0, 7 * PB, 0, 1'b0, 1'b0, 64'h8000_0100, "R7 seven scattered", 1'b0);
        run(0, 14 * PB, 0, 1'b0, 1'b0, 64'h8000_0200, "R7 fourteen scattered", 1'b0);
        run(0, 14 * PB, 2, 1'b0, 1'b0, 64'h8000_0300, "R7 last page merged", 1'b0);
        // R4: single-page buffer with both bounce pages, head wins
        run(9, 20, 0, 1'b1, 1'b1, 64'h8000_0400, "R4 single page bounce", 1'b0);
        run(9, 20, 0, 1'b0, 1'b1, 64'h8000_0480, "R4 single page tail bounce", 1'b0);
        // R8: length zero and capacity on both sides of the limit
        run(0, 0, 0, 1'b0, 1'b0, 64'h8000_0500, "R8", 1'b0);
        run(0, 27 * PB, 0, 1'b0, 1'b0, 64'h8000_0600, "R8 at capacity", 1'b0);
        run(0, 27 * PB + 1, 0, 1'b0, 1'b0, 64'h8000_0700, "R8", 1'b0);
        // R11: start ignored while busy
        run(3, 300, 0, 1'b0, 1'b0, 64'h8000_0800, "R11 restart ignored", 1'b1);

        // sweep
        for (int mi = 0; mi < 4; mi++)
            for (int bi = 0; bi < 4; bi++)
                for (int oi = 0; oi < 4; oi++)
                    for (int li = 0; li < 16; li++) begin
                        int off, len, n, dd;
                        string lbl;
                        off = (oi == 0) ? 0 : (oi == 1) ? 1 : (oi == 2) ? 17 : 63;
                        len = 1 + li * 53;
                        n = (off + len + PB - 1) / PB;
                        model(off, len, mi, bi[0], bi[1], 64'h9000_0000);
                        dd = exp_d;
                        if (dd % 7 == 0) lbl = "R7 sweep";
                        else if (bi != 0) lbl = "R4 sweep";
                        else if (mi == 1 || mi == 2) lbl = "R5 sweep";
                        else lbl = "R3 sweep";
                        if (n > 0) run(off, len, mi, bi[0], bi[1], 64'h9000_0000 + 64'(li * 128), lbl, 1'b0);
                    end

        chk(hold_bad == 0, "R9 stalled write held", 128'(hold_bad), 128'd0);
        summary_and_end();
    end
endmodule